// File: doc/BRIEF.md
# I2C Master Byte Buffer with Occupancy Thresholds

This block is the single byte buffer that an I2C master uses for both directions of a transfer. In transmit mode the processor loads bytes and the bus engine takes them off the head to shift onto the wire. In receive mode the engine deposits the bytes it clocks in and the processor removes them. A mode input chooses which side may write and which may read; strobes from the side that is not in that role are ignored.

The buffer reports how many bytes it holds, flags full and empty, and keeps a control word with a high-water and a low-water mark. A one-cycle event fires when the fill level lands on the high-water mark, so the processor can drain a receive burst in one go. Another event fires when the last byte is taken, so the processor can refill a transmit burst. A self-clearing flush bit in the control word discards all contents in a single clock.

Top module: `i2cm_byte_fifo`

## Requirements
- R1: After a synchronous active-low reset, level is 0, empty is 1, full is 0, head_data is 0, all event outputs are 0 and ctrl_rdata is 0.
- R2: With rx_mode = 0, cpu_push writes and eng_pop removes. With rx_mode = 1, eng_push writes and cpu_pop removes. Strobes from the other two inputs leave the level and the contents unchanged.
- R3: Bytes leave in the order they were written. head_data shows the oldest byte, or 0 when empty. A pop while empty changes nothing.
- R4: level gives the number of stored bytes, at most DEPTH (128). full is 1 exactly when level is 128, and empty is 1 exactly when level is 0.
- R5: A write at level 128 is dropped, and ovf pulses high for the following cycle. A read in that same cycle still takes place.
- R6: A write and a read in the same cycle at 0 < level < 128 leave the level unchanged.
- R7: A write to the control word stores the low-water mark from bits 7:0 and the high-water mark from bits 15:8. Both read back in the same positions on ctrl_rdata.
- R8: Bit 16 of a control write flushes the buffer on that clock edge, so level is 0 one cycle later. It overrides any write or read in the same cycle, raises no event and reads back as 0.
- R9: hi_evt is high for one cycle when level has just changed to the high-water mark that was in force before that edge. A flush does not raise it.
- R10: empty_evt is high for one cycle when a read has just brought the level from nonzero to 0.
- R11: lo_flag is 1 whenever level is less than or equal to the low-water mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_mode | input | 1 | 0: processor writes, engine reads; 1: engine writes, processor reads |
| cpu_push | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_pop | input | 1 | Processor read strobe |
| eng_push | input | 1 | Engine write strobe |
| eng_wdata | input | 8 | Engine write byte |
| eng_pop | input | 1 | Engine read strobe |
| head_data | output | 8 | Oldest stored byte, 0 when empty |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 17 | Control word: flush 16, high mark 15:8, low mark 7:0 |
| ctrl_rdata | output | 17 | Control word readback, bit 16 always 0 |
| level | output | 8 | Current byte count |
| full | output | 1 | Level equals depth |
| empty | output | 1 | Level is zero |
| lo_flag | output | 1 | Level at or below the low-water mark |
| hi_evt | output | 1 | One-cycle pulse on reaching the high-water mark |
| empty_evt | output | 1 | One-cycle pulse when a read empties the buffer |
| ovf | output | 1 | One-cycle pulse after a dropped write |

## Verification
The properties use the role-selected write and read strobes, as picked by rx_mode. They assume that rx_mode is held for the whole cycle in which a strobe is sampled. The high-water property compares against the mark as it stood one cycle earlier, so a threshold rewrite and a level change can fall on the same edge. The stimulus changes every input only at the falling edge. It mixes directed fills past full, reads past empty, strobes from the inactive side and flushes that collide with writes. It then runs a long random phase in which the marks are rewritten and the mode toggles while the buffer is partly full.

// File: rtl/i2cm_fifo_pkg.sv
// Shared constants and the control-word layout of the I2C master byte buffer.
package i2cm_fifo_pkg;
    localparam int BYTE_W    = 8;
    localparam int THR_W     = 8;
    localparam int CTRL_W    = 2 * THR_W + 1;
    localparam int FLUSH_BIT = 2 * THR_W;

    // Control word: flush on top, high-water mark in the middle, low-water mark at the bottom.
    typedef struct packed {
        logic             flush;
        logic [THR_W-1:0] hi;
        logic [THR_W-1:0] lo;
    } fifo_ctrl_t;
endpackage

// File: rtl/i2cm_fifo_store.sv
// Byte storage array with one write port and an asynchronous read of the head slot.
// Assumes the index inputs are already in range; contents carry no reset.
module i2cm_fifo_store
    import i2cm_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] mem [DEPTH];

    // Store an accepted byte at the tail slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Present the head slot without a clock delay.
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/i2cm_fifo_ptrs.sv
// Head/tail indices and the occupancy count. Drops writes when full and reads when empty,
// and a flush overrides both. Assumes DEPTH is a power of two so the indices wrap naturally.
module i2cm_fifo_ptrs #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          ovf
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic is_full;
    logic is_empty;
    logic do_push;
    logic do_pop;

    // Decide which requests are honoured this cycle and the resulting count.
    always_comb begin
        is_full   = (count == FULL_CNT);
        is_empty  = (count == '0);
        do_push   = push && !flush && !is_full;
        do_pop    = pop  && !flush && !is_empty;
        count_nxt = flush ? '0 : (count + CW'(do_push) - CW'(do_pop));
    end

    assign wr_en = do_push;

    // Advance indices and count, or clear them on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            ovf   <= push && !flush && is_full;
            count <= count_nxt;
            if (flush) begin
                wr_idx <= '0;
                rd_idx <= '0;
            end else begin
                if (do_push) wr_idx <= wr_idx + AW'(1);
                if (do_pop)  rd_idx <= rd_idx + AW'(1);
            end
        end
    end
endmodule

// File: rtl/i2cm_fifo_marks.sv
// Control word (water marks, self-clearing flush) and the threshold flags and events.
// Assumes count_nxt is the count that the next edge will load.
module i2cm_fifo_marks
    import i2cm_fifo_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  fifo_ctrl_t       ctrl_in,
    input  logic [CW-1:0]    count,
    input  logic [CW-1:0]    count_nxt,
    output logic             flush,
    output logic [THR_W-1:0] hi_q,
    output logic [THR_W-1:0] lo_q,
    output logic             hi_evt,
    output logic             empty_evt,
    output logic             lo_flag
);
    logic hit_hi;
    logic hit_zero;

    // Decode the flush request and the event conditions for the coming edge.
    always_comb begin
        flush    = ctrl_we && ctrl_in.flush;
        hit_hi   = !flush && (32'(count_nxt) == 32'(hi_q)) && (count_nxt != count);
        hit_zero = !flush && (count_nxt == '0) && (count != '0);
        lo_flag  = (32'(count) <= 32'(lo_q));
    end

    // Hold the water marks written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (ctrl_we) begin
            hi_q <= ctrl_in.hi;
            lo_q <= ctrl_in.lo;
        end
    end

    // Register the one-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_evt    <= 1'b0;
            empty_evt <= 1'b0;
        end else begin
            hi_evt    <= hit_hi;
            empty_evt <= hit_zero;
        end
    end
endmodule

// File: rtl/i2cm_byte_fifo.sv
// Shared transmit/receive byte buffer of an I2C master. rx_mode picks which side writes
// and which reads; strobes of the inactive side are ignored. Assumes a single clock domain.
module i2cm_byte_fifo
    import i2cm_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode,
    input  logic              cpu_push,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic              cpu_pop,
    input  logic              eng_push,
    input  logic [BYTE_W-1:0] eng_wdata,
    input  logic              eng_pop,
    output logic [BYTE_W-1:0] head_data,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [CW-1:0]     level,
    output logic              full,
    output logic              empty,
    output logic              lo_flag,
    output logic              hi_evt,
    output logic              empty_evt,
    output logic              ovf
);
    logic              push_sel;
    logic              pop_sel;
    logic [BYTE_W-1:0] push_byte;
    logic              wr_en;
    logic [AW-1:0]     wr_idx;
    logic [AW-1:0]     rd_idx;
    logic [BYTE_W-1:0] rd_data;
    logic [CW-1:0]     count;
    logic [CW-1:0]     count_nxt;
    logic              flush;
    logic [THR_W-1:0]  hi_q;
    logic [THR_W-1:0]  lo_q;
    fifo_ctrl_t        ctrl_in;

    // Route the active side's strobes and data into the buffer.
    always_comb begin
        push_sel  = rx_mode ? eng_push  : cpu_push;
        push_byte = rx_mode ? eng_wdata : cpu_wdata;
        pop_sel   = rx_mode ? cpu_pop   : eng_pop;
        ctrl_in   = fifo_ctrl_t'(ctrl_wdata);
    end

    i2cm_fifo_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_sel),
        .pop       (pop_sel),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .count     (count),
        .count_nxt (count_nxt),
        .ovf       (ovf)
    );

    i2cm_fifo_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_byte),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    i2cm_fifo_marks #(.CW(CW)) u_marks (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_in   (ctrl_in),
        .count     (count),
        .count_nxt (count_nxt),
        .flush     (flush),
        .hi_q      (hi_q),
        .lo_q      (lo_q),
        .hi_evt    (hi_evt),
        .empty_evt (empty_evt),
        .lo_flag   (lo_flag)
    );

    // Drive the status outputs from the registered count.
    always_comb begin
        level      = count;
        full       = (count == CW'(DEPTH));
        empty      = (count == '0);
        head_data  = empty ? '0 : rd_data;
        ctrl_rdata = {1'b0, hi_q, lo_q};
    end
endmodule

// File: rtl/i2cm_byte_fifo_chk.sv
// Temporal checks on the byte buffer's ports, bound into every instance of the top.
module i2cm_byte_fifo_chk #(
    parameter int DEPTH = 128
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_mode,
    input logic        cpu_push,
    input logic        cpu_pop,
    input logic        eng_push,
    input logic        eng_pop,
    input logic        ctrl_we,
    input logic [16:0] ctrl_wdata,
    input logic [16:0] ctrl_rdata,
    input logic [7:0]  level,
    input logic        full,
    input logic        empty,
    input logic        hi_evt,
    input logic        empty_evt,
    input logic        ovf
);
    logic push_r;
    logic pop_r;
    logic flush_r;

    // Role-selected requests as seen at the ports.
    always_comb begin
        push_r  = rx_mode ? eng_push : cpu_push;
        pop_r   = rx_mode ? cpu_pop  : eng_pop;
        flush_r = ctrl_we && ctrl_wdata[16];
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) 32'(level) <= DEPTH); // R4
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R4
    AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> $past(full)); // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (full && !pop_r && !flush_r) |=> full); // R5
    AST_PAIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (!full && !empty && push_r && pop_r && !flush_r) |=> $stable(level)); // R6
    AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (empty && pop_r && !push_r && !flush_r) |=> empty); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush_r |=> (empty && !empty_evt && !hi_evt)); // R8
    AST_HI_AT_MARK: assert property (@(posedge clk) disable iff (!rst_n) hi_evt |-> (32'(level) == 32'($past(ctrl_rdata[15:8])))); // R9
    AST_EMPTY_EVT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) empty_evt |-> empty); // R10
    AST_EMPTY_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) empty_evt |=> !empty_evt); // R10
endmodule

bind i2cm_byte_fifo i2cm_byte_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/i2cm_byte_fifo_bench.sv
module i2cm_byte_fifo_bench;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_mode = 1'b0;
    logic        cpu_push = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_pop = 1'b0;
    logic        eng_push = 1'b0;
    logic [7:0]  eng_wdata = '0;
    logic        eng_pop = 1'b0;
    logic [7:0]  head_data;
    logic        ctrl_we = 1'b0;
    logic [16:0] ctrl_wdata = '0;
    logic [16:0] ctrl_rdata;
    logic [7:0]  level;
    logic        full, empty, lo_flag, hi_evt, empty_evt, ovf;

    always #10 clk = ~clk;

    i2cm_byte_fifo #(.DEPTH(DEPTH)) u_i2cm_byte_fifo (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state
    byte unsigned q[$];
    int  hi_m = 0, lo_m = 0;
    bit  ovf_m = 0, hie_m = 0, eme_m = 0;
    int  hi_seen = 0, eme_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare();
        int sz = q.size();
        int hd = (sz > 0) ? int'(q[0]) : 0;
        chk(int'(level) == sz, "R4 level", int'(level), sz);
        chk(full == (sz == DEPTH), "R4 full", int'(full), int'(sz == DEPTH));
        chk(empty == (sz == 0), "R4 empty", int'(empty), int'(sz == 0));
        chk(int'(head_data) == hd, "R3 head", int'(head_data), hd);
        chk(ovf == ovf_m, "R5 ovf", int'(ovf), int'(ovf_m));
        chk(hi_evt == hie_m, "R9 hi_evt", int'(hi_evt), int'(hie_m));
        chk(empty_evt == eme_m, "R10 empty_evt", int'(empty_evt), int'(eme_m));
        chk(lo_flag == (sz <= lo_m), "R11 lo_flag", int'(lo_flag), int'(sz <= lo_m));
        chk(int'(ctrl_rdata) == (hi_m * 256 + lo_m), "R7 ctrl", int'(ctrl_rdata), hi_m * 256 + lo_m);
        if (hi_evt) hi_seen++;
        if (empty_evt) eme_seen++;
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic cycle(input bit rx, input bit cp, input byte unsigned cd, input bit cpo,
                         input bit ep, input byte unsigned ed, input bit epo,
                         input bit we, input logic [16:0] wd);
        bit fl, pu, po;
        byte unsigned pd;
        int old_sz, new_sz;
        rx_mode = rx; cpu_push = cp; cpu_wdata = cd; cpu_pop = cpo;
        eng_push = ep; eng_wdata = ed; eng_pop = epo; ctrl_we = we; ctrl_wdata = wd;
        fl = we && wd[16];
        pu = rx ? ep : cp;
        pd = rx ? ed : cd;
        po = rx ? cpo : epo;
        @(posedge clk);
        old_sz = q.size();
        if (fl) begin
            q.delete();
            ovf_m = 0;
        end else begin
            ovf_m = pu && (old_sz == DEPTH);
            if (po && old_sz > 0) void'(q.pop_front());
            if (pu && old_sz < DEPTH) q.push_back(pd);
        end
        new_sz = q.size();
        hie_m = !fl && (new_sz == hi_m) && (new_sz != old_sz);
        eme_m = !fl && (new_sz == 0) && (old_sz != 0);
        if (we) begin
            hi_m = int'(wd[15:8]);
            lo_m = int'(wd[7:0]);
        end
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 0, 0, 0, 0, '0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int sz;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(level == 0, "R1 level", int'(level), 0);
        chk(empty == 1'b1 && full == 1'b0, "R1 flags", int'({full, empty}), 1);
        chk(head_data == 0 && ctrl_rdata == 0, "R1 head/ctrl", int'(ctrl_rdata), 0);
        chk({hi_evt, empty_evt, ovf} == 3'b000, "R1 events", int'({hi_evt, empty_evt, ovf}), 0);
        idle();

        // R7: set high mark 5, low mark 2
        cycle(0, 0, 0, 0, 0, 0, 0, 1, {1'b0, 8'd5, 8'd2});
        chk(ctrl_rdata == {1'b0, 8'd5, 8'd2}, "R7 readback", int'(ctrl_rdata), 1282);

        // R4/R5/R9: transmit fill beyond full
        hi_seen = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            cycle(0, 1, byte'(i + 1), 0, 0, 0, 0, 0, '0);
            if (i == DEPTH) chk(ovf == 1'b1, "R5 ovf after drop", int'(ovf), 1);
        end
        chk(full == 1'b1 && level == 8'd128, "R4 full at 128", int'(level), 128);
        chk(hi_seen == 1, "R9 single hi_evt on fill", hi_seen, 1);

        // R2: inactive side strobes ignored in transmit mode
        for (int i = 0; i < 4; i++) cycle(0, 0, 0, 1, 1, 8'hEE, 0, 0, '0);
        chk(level == 8'd128 && head_data == 8'd1, "R2 inactive strobes", int'(level), 128);

        // R5: full with write and read together: read happens, write dropped
        cycle(0, 1, 8'hAA, 0, 0, 0, 1, 0, '0);
        chk(level == 8'd127 && ovf == 1'b1, "R5 read at full", int'(level), 127);

        // R3/R10: drain and over-read
        eme_seen = 0;
        for (int i = 0; i < DEPTH + 2; i++) cycle(0, 0, 0, 0, 0, 0, 1, 0, '0);
        chk(empty == 1'b1 && head_data == 0, "R3 over-read", int'(head_data), 0);
        chk(eme_seen == 1, "R10 empty_evt count", eme_seen, 1);

        // R2/R6: receive mode
        for (int i = 0; i < 10; i++) cycle(1, 0, 0, 0, 1, byte'(8'h40 + i), 0, 0, '0);
        for (int i = 0; i < 20; i++) cycle(1, 0, 0, 1, 1, byte'(8'h80 + i), 0, 0, '0);
        chk(level == 8'd10, "R6 paired level", int'(level), 10);
        for (int i = 0; i < 3; i++) cycle(1, 1, 8'h11, 0, 0, 0, 1, 0, '0);
        chk(level == 8'd10, "R2 inactive strobes rx", int'(level), 10);

        // R8: flush colliding with a write
        eme_seen = 0;
        cycle(1, 0, 0, 0, 1, 8'h77, 0, 1, {1'b1, 8'd5, 8'd2});
        chk(level == 0 && ctrl_rdata[16] == 1'b0, "R8 flush", int'(level), 0);
        chk(eme_seen == 0, "R8 no event", eme_seen, 0);
        cycle(1, 0, 0, 0, 1, 8'h99, 0, 0, '0);
        chk(head_data == 8'h99, "R8 fresh after flush", int'(head_data), 153);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            bit we = ($urandom_range(0, 39) == 0);
            logic [16:0] wd;
            wd[16]   = ($urandom_range(0, 3) == 0);
            wd[15:8] = 8'($urandom_range(0, DEPTH));
            wd[7:0]  = 8'($urandom_range(0, DEPTH));
            sz = $urandom_range(0, 9);
            cycle((i / 500) % 2 == 1, sz < 6, 8'($urandom), $urandom_range(0, 9) < 4,
                  sz < 6, 8'($urandom), $urandom_range(0, 9) < 4, we, wd);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule